// File: doc/BRIEF.md
# Character Dot Styling and Dual-Output Router

This block sits behind the raster generator and font lookup of an on-screen text overlay. For every dot position it receives a three-bit column slice of the glyph: the dot itself and the dots directly above and below it. It also receives the attribute bit of the character cell, the index of the character row on screen, and a flag that marks positions inside the text window. From these it produces a character level and a blanking level for two independent output systems. Keying or mixing logic further down the chain uses those levels.

Styling covers three features. Reverse video applies per cell, gated by a global enable. A blink timer makes reverse cells alternate between normal and reversed appearance. An optional outline marks blank dots that touch a glyph dot. A 12-bit row mask decides which character rows also appear on the second output system. Two mode bits set two further things: whether the first system drops the rows that the mask sends to the second system, and whether the blank outputs repeat the glyph dots or carry only the fill and outline dots. The blink timer counts vertical-sync pulses by default. A parameter switches it to a free-running clock divider.

Top module: `osd_attr_router`

## Requirements
- R1: While `rst_n` is low, all four outputs are low, whatever the other inputs do.
- R2: A dot presented while `disp_en` is low, or with `dot_act` low, produces low levels on all four outputs. A dot with `dot_act` low also counts as an empty neighbour.
- R3: A dot presented on the cycle before clock edge k appears on the outputs after edge k+1. In the plain case (no reverse, no outline, `blank_only` low), the character level equals the centre glyph bit `dot_col[1]`, and the blank level equals the character level.
- R4: When `rev_en` is high and `dot_attr` is set (and blinking does not hold the normal phase), the character level is the inverse of the glyph bit and the blank level is high. Cells with `dot_attr` clear, and every cell while `rev_en` is low, are drawn normally.
- R5: The blink phase starts at 0 after reset. It toggles after every 15 `vs_tick` pulses when `blink_slow` is low, and after every 30 when it is high. While `blink_en` is high, reverse cells appear normal in phase 0 and reversed in phase 1.
- R6: With `border_en` high, a dot of a non-reversed cell whose own glyph bit is 0 gets a high blank level and a low character level when any of its four neighbours is a glyph dot. The four neighbours are above (`dot_col[2]`), below (`dot_col[0]`), the previous presented dot and the next presented dot.
- R7: With `blank_only` high, the blank level comes only from outline dots and reverse cells, and never from glyph dots alone.
- R8: Character row r in the range 0 to 11 reaches `cha2`/`blk2` only when `line_mask[r]` is 1. Row indices of 12 and above never reach the second system.
- R9: With `sys1_excl` low, `cha1`/`blk1` carry every row. With it high, they carry only the rows not routed to the second system.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted in step with `clk` |
| disp_en | input | 1 | Global display enable |
| rev_en | input | 1 | Global reverse-video enable |
| blink_en | input | 1 | Enables blinking of reverse cells |
| blink_slow | input | 1 | Selects the long blink period |
| border_en | input | 1 | Enables the glyph outline |
| blank_only | input | 1 | Blank outputs carry fill/outline dots only |
| sys1_excl | input | 1 | First system omits rows routed to the second |
| line_mask | input | 12 | Per-row routing to the second system, bit r for row r |
| vs_tick | input | 1 | One-cycle pulse per vertical sync |
| dot_act | input | 1 | Dot lies inside the text window |
| dot_attr | input | 1 | Reverse attribute of the dot's cell |
| dot_row | input | 4 | Character row index of the dot |
| dot_col | input | 3 | Glyph bits: [2] above, [1] centre, [0] below |
| cha1 | output | 1 | First system character level |
| blk1 | output | 1 | First system blank level |
| cha2 | output | 1 | Second system character level |
| blk2 | output | 1 | Second system blank level |

## Verification
The assertions assume that `rst_n` is already synchronous to `clk` on release, and that each `vs_tick` is a single-cycle pulse. The configuration inputs are assumed to stay steady around the dots whose outcome a check depends on. The stimulus follows these rules: it changes mode bits only after a run of window-outside dots, so no dot in flight sees a change. It issues sync pulses only between such idle dots, one cycle each. It drives every input on the falling clock edge.

// File: rtl/osd_pkg.sv
package osd_pkg;

  // Bit positions inside the per-dot glyph column slice.
  localparam int unsigned COL_BELOW = 0;
  localparam int unsigned COL_MID   = 1;
  localparam int unsigned COL_ABOVE = 2;
  localparam int unsigned COL_W     = 3;

  // Number of output systems driven by the router.
  localparam int unsigned NUM_SYS   = 2;

  typedef struct packed {
    logic cha;
    logic blk;
  } osd_pair_t;

  typedef struct packed {
    logic             act;
    logic             attr;
    logic [COL_W-1:0] col;
  } osd_dot_t;

endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter bit          FROM_VSYNC = 1'b1,
  parameter int unsigned FAST_HALF  = 15,
  parameter int unsigned SLOW_HALF  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic slow,
  output logic phase
);

  localparam int unsigned MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);

  logic             step;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             phase_d;

  generate
    if (FROM_VSYNC) begin : g_vsync
      assign step = tick;
    end else begin : g_divider
      logic unused_tick;
      assign unused_tick = tick;
      assign step        = 1'b1;
    end
  endgenerate

  assign last = slow ? SLOW_LAST : FAST_LAST;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase;
    if (step) begin
      if (cnt_q >= last) begin
        cnt_d   = '0;
        phase_d = ~phase;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_d;
      phase <= phase_d;
    end
  end

endmodule

// File: rtl/osd_dot_shaper.sv
module osd_dot_shaper
  import osd_pkg::*;
#(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_act,
  input  logic             in_attr,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic             rev_en,
  input  logic             blink_en,
  input  logic             blink_ph,
  input  logic             border_en,
  input  logic             blank_only,
  output logic             mid_act,
  output logic [ROW_W-1:0] mid_row,
  output osd_pair_t        mid_pair
);

  // Three-dot horizontal window: next (live input), mid, prev.
  osd_dot_t         nxt_dot;
  osd_dot_t         mid_q, prev_q;
  logic [ROW_W-1:0] row_q;

  logic glyph, vert_nb, horz_nb, any_nb, rev_on, edge_dot, cha_c;

  always_comb begin
    nxt_dot.act  = in_act;
    nxt_dot.attr = in_attr & in_act;
    nxt_dot.col  = in_act ? in_col : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= '0;
      prev_q <= '0;
      row_q  <= '0;
    end else begin
      mid_q  <= nxt_dot;
      prev_q <= mid_q;
      row_q  <= in_row;
    end
  end

  always_comb begin
    glyph    = mid_q.col[COL_MID];
    vert_nb  = mid_q.col[COL_ABOVE] | mid_q.col[COL_BELOW];
    horz_nb  = prev_q.col[COL_MID] | nxt_dot.col[COL_MID];
    any_nb   = vert_nb | horz_nb;
    rev_on   = rev_en & mid_q.attr & (~blink_en | blink_ph);
    cha_c    = rev_on ? ~glyph : glyph;
    edge_dot = border_en & ~rev_on & ~glyph & any_nb;
    mid_pair.cha = cha_c;
    mid_pair.blk = edge_dot | rev_on | (~blank_only & cha_c);
  end

  assign mid_act = mid_q.act;
  assign mid_row = row_q;

endmodule

// File: rtl/osd_line_router.sv
module osd_line_router
  import osd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 12,
  parameter int unsigned ROW_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_en,
  input  logic                sys1_excl,
  input  logic [NUM_ROWS-1:0] line_mask,
  input  logic                mid_act,
  input  logic [ROW_W-1:0]    mid_row,
  input  osd_pair_t           mid_pair,
  output osd_pair_t           sys_out [NUM_SYS]
);

  localparam int unsigned ROW_SPAN = 1 << ROW_W;
  localparam int unsigned PAD      = ROW_SPAN - NUM_ROWS;

  logic [ROW_SPAN-1:0] mask_ext;
  logic                to_sec;
  logic                live;
  logic [NUM_SYS-1:0]  sys_en;

  assign mask_ext = {{PAD{1'b0}}, line_mask};
  assign to_sec   = mask_ext[mid_row];
  assign live     = disp_en & mid_act;

  always_comb begin
    sys_en    = '0;
    sys_en[0] = live & ~(sys1_excl & to_sec);
    sys_en[1] = live & to_sec;
  end

  generate
    for (genvar s = 0; s < NUM_SYS; s++) begin : g_sys
      osd_pair_t nxt;

      always_comb begin
        nxt.cha = sys_en[s] & mid_pair.cha;
        nxt.blk = sys_en[s] & mid_pair.blk;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sys_out[s] <= '0;
        end else begin
          sys_out[s] <= nxt;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/osd_attr_router.sv
module osd_attr_router
  import osd_pkg::*;
#(
  parameter int unsigned NUM_ROWS         = 12,
  parameter bit          BLINK_FROM_VSYNC = 1'b1,
  parameter int unsigned BLINK_FAST_HALF  = 15,
  parameter int unsigned BLINK_SLOW_HALF  = 30,
  localparam int unsigned ROW_W           = $clog2(NUM_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_en,
  input  logic                rev_en,
  input  logic                blink_en,
  input  logic                blink_slow,
  input  logic                border_en,
  input  logic                blank_only,
  input  logic                sys1_excl,
  input  logic [NUM_ROWS-1:0] line_mask,
  input  logic                vs_tick,
  input  logic                dot_act,
  input  logic                dot_attr,
  input  logic [ROW_W-1:0]    dot_row,
  input  logic [COL_W-1:0]    dot_col,
  output logic                cha1,
  output logic                blk1,
  output logic                cha2,
  output logic                blk2
);

  logic             blink_ph;
  logic             mid_act;
  logic [ROW_W-1:0] mid_row;
  osd_pair_t        mid_pair;
  osd_pair_t        sys_out [NUM_SYS];

  osd_blink_timer #(
    .FROM_VSYNC (BLINK_FROM_VSYNC),
    .FAST_HALF  (BLINK_FAST_HALF),
    .SLOW_HALF  (BLINK_SLOW_HALF)
  ) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (vs_tick),
    .slow  (blink_slow),
    .phase (blink_ph)
  );

  osd_dot_shaper #(
    .ROW_W (ROW_W)
  ) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_act     (dot_act),
    .in_attr    (dot_attr),
    .in_row     (dot_row),
    .in_col     (dot_col),
    .rev_en     (rev_en),
    .blink_en   (blink_en),
    .blink_ph   (blink_ph),
    .border_en  (border_en),
    .blank_only (blank_only),
    .mid_act    (mid_act),
    .mid_row    (mid_row),
    .mid_pair   (mid_pair)
  );

  osd_line_router #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .disp_en   (disp_en),
    .sys1_excl (sys1_excl),
    .line_mask (line_mask),
    .mid_act   (mid_act),
    .mid_row   (mid_row),
    .mid_pair  (mid_pair),
    .sys_out   (sys_out)
  );

  assign cha1 = sys_out[0].cha;
  assign blk1 = sys_out[0].blk;
  assign cha2 = sys_out[1].cha;
  assign blk2 = sys_out[1].blk;

endmodule

// File: rtl/osd_attr_router_chk.sv
module osd_attr_router_chk #(
  parameter int unsigned NUM_ROWS   = 12,
  parameter int unsigned ROW_W      = 4,
  parameter bit          FROM_VSYNC = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                disp_en,
  input logic                rev_en,
  input logic                border_en,
  input logic                blank_only,
  input logic                sys1_excl,
  input logic [NUM_ROWS-1:0] line_mask,
  input logic                vs_tick,
  input logic                dot_act,
  input logic [ROW_W-1:0]    dot_row,
  input logic                cha1,
  input logic                blk1,
  input logic                cha2,
  input logic                blk2,
  input logic                blink_ph
);

  localparam int unsigned ROW_SPAN = 1 << ROW_W;
  localparam int unsigned PAD      = ROW_SPAN - NUM_ROWS;

  logic [1:0]          seen;
  logic                act_q1, act_q2;
  logic [ROW_W-1:0]    row_q1, row_q2;
  logic                disp_q, excl_q, bonly_q, rev_q, bord_q;
  logic [ROW_SPAN-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      act_q1  <= 1'b0;
      act_q2  <= 1'b0;
      row_q1  <= '0;
      row_q2  <= '0;
      disp_q  <= 1'b0;
      excl_q  <= 1'b0;
      bonly_q <= 1'b0;
      rev_q   <= 1'b0;
      bord_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (seen != 2'd2) seen <= seen + 2'd1;
      act_q1  <= dot_act;
      act_q2  <= act_q1;
      row_q1  <= dot_row;
      row_q2  <= row_q1;
      disp_q  <= disp_en;
      excl_q  <= sys1_excl;
      bonly_q <= blank_only;
      rev_q   <= rev_en;
      bord_q  <= border_en;
      mask_q  <= {{PAD{1'b0}}, line_mask};
    end
  end

  // R2
  disp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2 && (!disp_q || !act_q2)) |-> !(cha1 | blk1 | cha2 | blk2));

  // R8
  sec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2 && (cha2 | blk2)) |-> mask_q[row_q2]);

  // R9
  pri_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2 && excl_q && (cha2 | blk2)) |-> !(cha1 | blk1));

  // R7
  blank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd2 && bonly_q && !rev_q && !bord_q) |-> !(blk1 | blk2));

  generate
    if (FROM_VSYNC) begin : g_blink_chk
      // R5
      blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && !$past(vs_tick)) |-> $stable(blink_ph));
    end
  endgenerate

endmodule

bind osd_attr_router osd_attr_router_chk #(
  .NUM_ROWS   (NUM_ROWS),
  .ROW_W      (ROW_W),
  .FROM_VSYNC (BLINK_FROM_VSYNC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_en    (disp_en),
  .rev_en     (rev_en),
  .border_en  (border_en),
  .blank_only (blank_only),
  .sys1_excl  (sys1_excl),
  .line_mask  (line_mask),
  .vs_tick    (vs_tick),
  .dot_act    (dot_act),
  .dot_row    (dot_row),
  .cha1       (cha1),
  .blk1       (blk1),
  .cha2       (cha2),
  .blk2       (blk2),
  .blink_ph   (blink_ph)
);

// File: tb/osd_attr_router_bench.sv
module osd_attr_router_bench;

  localparam int FAST = 15;
  localparam int SLOW = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        disp_en, rev_en, blink_en, blink_slow, border_en, blank_only, sys1_excl;
  logic [11:0] line_mask;
  logic        vs_tick, dot_act, dot_attr;
  logic [3:0]  dot_row;
  logic [2:0]  dot_col;
  logic        cha1, blk1, cha2, blk2;

  always #4 clk = ~clk;

  osd_attr_router u_osd_attr_router (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .rev_en(rev_en),
    .blink_en(blink_en), .blink_slow(blink_slow), .border_en(border_en),
    .blank_only(blank_only), .sys1_excl(sys1_excl), .line_mask(line_mask),
    .vs_tick(vs_tick), .dot_act(dot_act), .dot_attr(dot_attr),
    .dot_row(dot_row), .dot_col(dot_col),
    .cha1(cha1), .blk1(blk1), .cha2(cha2), .blk2(blk2)
  );

  typedef struct { bit act; bit attr; int row; bit [2:0] col; } pix_t;
  typedef struct { bit [3:0] v; string tag; } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    failures = 0;
  string cur_tag = "R3";
  pix_t  pp, p;
  bit    ph_m = 1'b0;
  int    tick_m = 0;
  bit    done = 1'b0;

  function automatic bit [3:0] model(pix_t l, pix_t m, pix_t r);
    bit c, nb, rv, ch, bd, bk, to2, s1;
    if (!disp_en || !m.act) return 4'b0000;
    c   = m.col[1];
    nb  = m.col[2] | m.col[0] | (l.act & l.col[1]) | (r.act & r.col[1]);
    rv  = rev_en & m.attr & (!blink_en | ph_m);
    ch  = rv ? !c : c;
    bd  = border_en & !rv & !c & nb;
    bk  = bd | rv | (!blank_only & ch);
    to2 = (m.row < 12) ? line_mask[m.row] : 1'b0;
    s1  = !(sys1_excl & to2);
    return {s1 & ch, s1 & bk, to2 & ch, to2 & bk};
  endfunction

  task automatic drive(bit act, bit [2:0] col, bit attr, int row, bit tick);
    pix_t cur;
    exp_t e;
    @(negedge clk);
    dot_act  = act;
    dot_col  = col;
    dot_attr = attr;
    dot_row  = 4'(row);
    vs_tick  = tick;
    cur = '{act: act, attr: attr, row: row, col: col};
    e.v = model(pp, p, cur);
    e.tag = cur_tag;
    sb_q.push_back(e);
    if (tick) begin
      if (tick_m >= (blink_slow ? SLOW : FAST) - 1) begin
        tick_m = 0;
        ph_m = !ph_m;
      end else begin
        tick_m++;
      end
    end
    pp = p;
    p  = cur;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 3'b000, 1'b0, 0, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 3'b000, 1'b0, 0, 1'b1);
      idle(1);
    end
  endtask

  // A short glyph strip exercising several centre/neighbour patterns.
  task automatic strip(int row, bit attr);
    drive(1'b1, 3'b000, attr, row, 1'b0);
    drive(1'b1, 3'b010, attr, row, 1'b0);
    drive(1'b1, 3'b000, attr, row, 1'b0);
    drive(1'b1, 3'b100, attr, row, 1'b0);
    drive(1'b1, 3'b001, attr, row, 1'b0);
    drive(1'b1, 3'b000, attr, row, 1'b0);
    drive(1'b1, 3'b000, attr, row, 1'b0);
    drive(1'b1, 3'b111, attr, row, 1'b0);
    drive(1'b1, 3'b010, attr, row, 1'b0);
    drive(1'b1, 3'b101, attr, row, 1'b0);
    idle(3);
  endtask

  // Monitor: pops one expected item per clock after each edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ({cha1, blk1, cha2, blk2} !== e.v) begin
        failures++;
        $display("FAIL %s outputs {cha1,blk1,cha2,blk2} actual=%b expected=%b at %0t",
                 e.tag, {cha1, blk1, cha2, blk2}, e.v, $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pp = '{act: 0, attr: 0, row: 0, col: 3'b000};
    p  = pp;
    rst_n = 1'b0;
    disp_en = 1'b1; rev_en = 1'b1; blink_en = 1'b0; blink_slow = 1'b0;
    border_en = 1'b1; blank_only = 1'b0; sys1_excl = 1'b0; line_mask = 12'hFFF;
    vs_tick = 1'b0; dot_act = 1'b1; dot_attr = 1'b1; dot_row = 4'd0; dot_col = 3'b111;
    repeat (4) @(posedge clk);
    #2;
    // R1: busy inputs under reset leave outputs low
    checks++;
    if ({cha1, blk1, cha2, blk2} !== 4'b0000) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b expected=0000", {cha1, blk1, cha2, blk2});
    end
    @(negedge clk);
    disp_en = 1'b1; rev_en = 1'b0; border_en = 1'b0; line_mask = 12'h000;
    dot_act = 1'b0; dot_attr = 1'b0; dot_col = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    cur_tag = "R3";  strip(0, 1'b0);
    cur_tag = "R2";  disp_en = 1'b0; strip(1, 1'b0); disp_en = 1'b1;
    cur_tag = "R2";  for (int i = 0; i < 4; i++) drive(1'b0, 3'b111, 1'b1, 2, 1'b0);
    drive(1'b1, 3'b000, 1'b0, 2, 1'b0); drive(1'b0, 3'b010, 1'b0, 2, 1'b0); idle(2);

    cur_tag = "R4";  strip(3, 1'b1);
    rev_en = 1'b1;   strip(3, 1'b1); strip(4, 1'b0);

    cur_tag = "R6";  border_en = 1'b1; strip(5, 1'b0); strip(5, 1'b1);
    rev_en = 1'b0;   strip(6, 1'b1);

    cur_tag = "R7";  blank_only = 1'b1; strip(7, 1'b0);
    border_en = 1'b0; strip(7, 1'b1);
    rev_en = 1'b1;   strip(7, 1'b1); blank_only = 1'b0;

    cur_tag = "R5";  blink_en = 1'b1; strip(8, 1'b1);
    ticks(FAST - 1); strip(8, 1'b1);
    ticks(1);        strip(8, 1'b1);
    blink_slow = 1'b1;
    ticks(SLOW - 1); strip(8, 1'b1);
    ticks(1);        strip(8, 1'b1);
    blink_en = 1'b0; rev_en = 1'b0;

    cur_tag = "R8";  line_mask = 12'b1000_0000_1001;
    strip(0, 1'b0); strip(3, 1'b0); strip(11, 1'b0); strip(5, 1'b0);
    line_mask = 12'hFFF; strip(12, 1'b0); strip(15, 1'b0);

    cur_tag = "R9";  sys1_excl = 1'b1; line_mask = 12'b0000_0100_0010;
    strip(1, 1'b0); strip(6, 1'b0); strip(2, 1'b0); strip(12, 1'b0);
    sys1_excl = 1'b0; strip(1, 1'b0);

    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule